// File: doc/BRIEF.md
# Self-Correcting Serial Pattern Generator

The block emits the six-bit pattern 1,0,1,1,0,0 on a single serial output and repeats it for as long as it is enabled. It is built from a 4-bit shift register that moves its contents toward the most significant end on every enabled clock. The bit that enters at the least significant end comes from a feedback function of the current contents. That function is a lookup in an eight-slot selector. Three state bits address the selector, and each slot holds a constant 0, a constant 1, or the remaining state bit. The serial output is the register's most significant bit.

The feedback table is chosen so that the generator corrects itself. All ten 4-bit values that are not windows of the pattern lead into the six-state pattern cycle within a few clocks. A register disturbed into any value therefore returns to the correct output stream without a reset. A synchronous reset starts the stream at its first bit. A preset load path places any chosen value into the register. This lets the self-correction be exercised from every possible starting state.

Top module: `seq_gen_top`

## Requirements
- R1: The serial output `dout` always equals bit 3 (the most significant bit) of `sr_state`.
- R2: When `rst` is high at a rising clock edge, `sr_state` becomes 4'b1011 after that edge. This happens whatever the values of `load` and `en`.
- R3: When `rst` and `load` are low and `en` is high, each clock moves `sr_state[2:0]` into `sr_state[3:1]`, and the feedback bit enters `sr_state[0]`.
- R4: When `rst`, `load` and `en` are all low, `sr_state` keeps its value across the clock edge.
- R5: When `rst` is low and `load` is high, `sr_state` takes the value of `load_val` at that edge, whatever the value of `en`.
- R6: The feedback bit is an eight-slot lookup addressed by `sr_state[2:0]`. The slots hold these values: slot 0 = 1, slot 1 = 0, slot 2 = 1, slot 3 = 0, slot 4 = `sr_state[3]`, slot 5 = 1, slot 6 = 0, slot 7 = 0.
- R7: After reset, with `en` held high, `dout` shows 1,0,1,1,0,0 and then repeats that group.
- R8: The main cycle is 1011 → 0110 → 1100 → 1001 → 0010 → 0101 → 1011. From any of these values, one enabled shift produces the next value in that order.
- R9: From each of the ten values outside the main cycle, at most 4 enabled shifts reach the main cycle. The default table needs at most 3. After that, `dout` repeats with period 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, loads 4'b1011 |
| en | input | 1 | Shift enable; when low the register holds |
| load | input | 1 | Preset strobe; copies `load_val` into the register |
| load_val | input | 4 | Preset value |
| dout | output | 1 | Serial pattern bit (register MSB) |
| sr_state | output | 4 | Current shift register contents |

## Verification
The bench seeds the register with each of the sixteen possible values. A wrong feedback slot shows up in two ways: the bit shifted in after one clock is wrong, or a value that should be in the cycle steps out of it. A table that is not self-correcting is caught because the bench counts shifts until the cycle is reached. An unused value that locks up, or one that needs more than four shifts to enter the cycle, fails that count. The bench also targets the order of the control inputs. Reset must win over a simultaneous load, and load must win when enable is low. A register that keeps shifting while disabled is caught because its value drifts during the hold window.

// File: rtl/seqgen_pkg.sv
`timescale 1ns/1ps
package seqgen_pkg;
   // Feedback slot source codes (2 bits per slot)
   localparam logic [1:0] FB_ZERO = 2'd0;
   localparam logic [1:0] FB_ONE  = 2'd1;
   localparam logic [1:0] FB_TAP  = 2'd2;
   localparam int unsigned FB_CODE_W = 2;
endpackage

// File: rtl/seq_fb_mux.sv
`timescale 1ns/1ps
module seq_fb_mux #(
   parameter int unsigned SEL_W   = 3,
   parameter logic [seqgen_pkg::FB_CODE_W*(2**SEL_W)-1:0] SRC_CFG = 16'h0611
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             tap,
   output logic             fb
);
   import seqgen_pkg::*;
   localparam int unsigned N_SLOT = 2**SEL_W;

   if (SEL_W < 1) begin : g_bad_sel
      $error("seq_fb_mux: SEL_W must be at least 1");
   end

   logic [N_SLOT-1:0] slot_d;

   for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
      localparam logic [FB_CODE_W-1:0] CODE = SRC_CFG[FB_CODE_W*g +: FB_CODE_W];
      if (CODE == FB_ZERO) begin : g_zero
         assign slot_d[g] = 1'b0;
      end else if (CODE == FB_ONE) begin : g_one
         assign slot_d[g] = 1'b1;
      end else if (CODE == FB_TAP) begin : g_tap
         assign slot_d[g] = tap;
      end else begin : g_bad
         assign slot_d[g] = 1'b0;
         $error("seq_fb_mux: invalid slot source code");
      end
   end

   assign fb = slot_d[sel];
endmodule

// File: rtl/seq_shift_reg.sv
`timescale 1ns/1ps
module seq_shift_reg #(
   parameter int unsigned W = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         fb,
   output logic [W-1:0] q
);
   if (W < 2) begin : g_bad_w
      $error("seq_shift_reg: W must be at least 2");
   end

   logic [W-1:0] shifted;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         assign shifted[i] = fb;
      end else begin : g_up
         assign shifted[i] = q[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)       q <= RST_VAL;
      else if (load) q <= load_val;
      else if (en)   q <= shifted;
   end

   // R2: reset wins over every other control
   assert_reset_value_R2: assert property (@(posedge clk)
      rst |=> (q == RST_VAL));
   // R5: preset wins over enable
   assert_preset_R5: assert property (@(posedge clk) disable iff (rst)
      load |=> (q == $past(load_val)));
   // R4: idle register keeps its contents
   assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!load && !en) |=> $stable(q));
   // R3: enabled shift moves bits toward the MSB
   assert_shift_dir_R3: assert property (@(posedge clk) disable iff (rst)
      (!load && en) |=> (q[W-1:1] == $past(q[W-2:0])));
endmodule

// File: rtl/seq_gen_top.sv
`timescale 1ns/1ps
module seq_gen_top #(
   parameter int unsigned W         = 4,
   parameter int unsigned PAT_LEN   = 6,
   parameter logic [PAT_LEN-1:0] PATTERN = 6'b101100,
   parameter logic [seqgen_pkg::FB_CODE_W*(2**(W-1))-1:0] FB_SRC = 16'h0611,
   parameter int unsigned MAX_CONV  = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         dout,
   output logic [W-1:0] sr_state
);
   import seqgen_pkg::*;
   localparam int unsigned SEL_W = W - 1;
   localparam int unsigned N_ST  = 2**W;
   localparam int unsigned IDX_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
   localparam int unsigned CNT_W = $clog2(MAX_CONV + 1) + 1;

   // ---- constant helpers ----
   function automatic logic pat_bit(input int i);
      return PATTERN[PAT_LEN - 1 - (i % PAT_LEN)];
   endfunction

   function automatic logic [W-1:0] window(input int k);
      logic [W-1:0] w;
      for (int j = 0; j < W; j++) w[W-1-j] = pat_bit(k + j);
      return w;
   endfunction

   function automatic logic fb_of(input logic [W-1:0] s);
      logic [FB_CODE_W-1:0] code;
      code = FB_SRC[FB_CODE_W*int'(s[SEL_W-1:0]) +: FB_CODE_W];
      if (code == FB_ONE) return 1'b1;
      if (code == FB_TAP) return s[W-1];
      return 1'b0;
   endfunction

   function automatic logic is_window(input logic [W-1:0] s);
      for (int k = 0; k < PAT_LEN; k++) if (s == window(k)) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic windows_distinct();
      for (int a = 0; a < PAT_LEN; a++)
         for (int b = a + 1; b < PAT_LEN; b++)
            if (window(a) == window(b)) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic table_follows_pattern();
      for (int k = 0; k < PAT_LEN; k++)
         if (fb_of(window(k)) != pat_bit(k + W)) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic all_converge();
      logic [W-1:0] cur;
      logic         hit;
      for (int s = 0; s < N_ST; s++) begin
         cur = W'(s);
         hit = 1'b0;
         for (int n = 0; n <= MAX_CONV; n++) begin
            if (is_window(cur)) hit = 1'b1;
            cur = {cur[W-2:0], fb_of(cur)};
         end
         if (!hit) return 1'b0;
      end
      return 1'b1;
   endfunction

   localparam logic [W-1:0] START_WIN = window(0);

   // ---- elaboration checks ----
   if (W < 2 || PAT_LEN < 2) begin : g_bad_size
      $error("seq_gen_top: W and PAT_LEN must be at least 2");
   end
   if (!windows_distinct()) begin : g_bad_width
      $error("seq_gen_top: register too narrow for the pattern");
   end
   if (!table_follows_pattern()) begin : g_bad_table
      $error("seq_gen_top: feedback table does not produce the pattern");
   end
   if (!all_converge()) begin : g_bad_conv
      $error("seq_gen_top: feedback table is not self-correcting");
   end

   // ---- datapath ----
   logic fb_bit;

   seq_fb_mux #(
      .SEL_W  (SEL_W),
      .SRC_CFG(FB_SRC)
   ) u_fb (
      .sel(sr_state[SEL_W-1:0]),
      .tap(sr_state[W-1]),
      .fb (fb_bit)
   );

   seq_shift_reg #(
      .W      (W),
      .RST_VAL(START_WIN)
   ) u_sr (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .load    (load),
      .load_val(load_val),
      .fb      (fb_bit),
      .q       (sr_state)
   );

   assign dout = sr_state[W-1];

   // ---- checker state ----
   logic             in_cyc;
   logic [IDX_W-1:0] cyc_idx;
   logic [W-1:0]     exp_next;
   logic [CNT_W-1:0] conv_cnt;

   always_comb begin
      in_cyc  = 1'b0;
      cyc_idx = '0;
      for (int k = 0; k < PAT_LEN; k++) begin
         if (sr_state == window(k)) begin
            in_cyc  = 1'b1;
            cyc_idx = IDX_W'(k);
         end
      end
      exp_next = window((int'(cyc_idx) + 1) % PAT_LEN);
   end

   always_ff @(posedge clk) begin
      if (rst || load)
         conv_cnt <= '0;
      else if (en && !in_cyc && conv_cnt != CNT_W'(MAX_CONV))
         conv_cnt <= conv_cnt + 1'b1;
   end

   // R8: inside the cycle each shift steps to the next pattern window
   assert_cycle_step_R8: assert property (@(posedge clk) disable iff (rst)
      (in_cyc && en && !load) |=> (sr_state == $past(exp_next)));
   // R9: an unused value may not survive MAX_CONV shifts
   assert_converge_R9: assert property (@(posedge clk) disable iff (rst)
      !in_cyc |-> (conv_cnt < CNT_W'(MAX_CONV)));
   // R7: the first output bit after reset is the pattern's first bit
   assert_first_bit_R7: assert property (@(posedge clk)
      rst |=> (dout == pat_bit(0)));
endmodule

// File: tb/tb_seq_gen_top.sv
`timescale 1ns/1ps
module tb_seq_gen_top;
   logic       clk = 1'b0;
   logic       rst = 1'b0;
   logic       en = 1'b0;
   logic       load = 1'b0;
   logic [3:0] load_val = 4'd0;
   logic       dout;
   logic [3:0] sr_state;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   seq_gen_top dut (
      .clk(clk), .rst(rst), .en(en), .load(load),
      .load_val(load_val), .dout(dout), .sr_state(sr_state)
   );

   always #10 clk = ~clk;

   // Cycle windows from R8, in order
   function automatic logic [3:0] win(input int k);
      case (k % 6)
         0: return 4'b1011;
         1: return 4'b0110;
         2: return 4'b1100;
         3: return 4'b1001;
         4: return 4'b0010;
         default: return 4'b0101;
      endcase
   endfunction

   function automatic int win_idx(input logic [3:0] s);
      for (int k = 0; k < 6; k++) if (win(k) == s) return k;
      return -1;
   endfunction

   // Feedback table from R6
   function automatic logic fb_exp(input logic [3:0] s);
      case (s[2:0])
         3'd0: return 1'b1;
         3'd1: return 1'b0;
         3'd2: return 1'b1;
         3'd3: return 1'b0;
         3'd4: return s[3];
         3'd5: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic seed(input logic [3:0] v);
      load = 1'b1; load_val = v; en = 1'b0;
      tick();
      load = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1; load = 1'b1; load_val = 4'b0000; en = 1'b1;
      tick();
      chk(sr_state == 4'b1011, "R2 reset over load/en", sr_state, 4'b1011);
      chk(dout == 1'b1, "R1 dout is MSB after reset", dout, 1);
      rst = 1'b0; load = 1'b0; en = 1'b0;
   endtask

   task automatic t_pattern();
      logic [5:0] pat = 6'b101100;
      rst = 1'b1; tick(); rst = 1'b0; en = 1'b1;
      for (int i = 0; i < 18; i++) begin
         chk(dout == pat[5 - (i % 6)], "R7 pattern bit", dout, pat[5 - (i % 6)]);
         chk(sr_state == win(i), "R8 cycle order", sr_state, win(i));
         chk(dout == sr_state[3], "R1 dout equals MSB", dout, sr_state[3]);
         tick();
      end
      en = 1'b0;
   endtask

   task automatic t_hold();
      logic [3:0] held;
      rst = 1'b1; tick(); rst = 1'b0; en = 1'b1;
      tick(); tick();
      en = 1'b0;
      held = sr_state;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk(sr_state == held, "R4 hold while disabled", sr_state, held);
      end
      en = 1'b1;
      tick();
      chk(sr_state == win(3), "R4 resume after hold", sr_state, win(3));
      en = 1'b0;
   endtask

   task automatic t_preset();
      load = 1'b1; load_val = 4'b0111; en = 1'b0;
      tick();
      chk(sr_state == 4'b0111, "R5 preset with en low", sr_state, 4'b0111);
      load_val = 4'b1000; en = 1'b1;
      tick();
      chk(sr_state == 4'b1000, "R5 preset over en", sr_state, 4'b1000);
      load = 1'b0; en = 1'b0;
   endtask

   task automatic t_feedback();
      for (int s = 0; s < 16; s++) begin
         logic [3:0] exp;
         seed(4'(s));
         en = 1'b1;
         tick();
         en = 1'b0;
         exp = {4'(s) << 1} | {3'b000, fb_exp(4'(s))};
         chk(sr_state == exp, "R3/R6 one shift from seed", sr_state, exp);
      end
   endtask

   task automatic t_converge();
      for (int s = 0; s < 16; s++) begin
         int steps = 0;
         logic [11:0] hist;
         seed(4'(s));
         en = 1'b1;
         while (win_idx(sr_state) < 0 && steps < 6) begin
            tick();
            steps++;
         end
         chk(steps <= 4, "R9 shifts to reach cycle", steps, 4);
         for (int i = 0; i < 12; i++) begin
            int idx = win_idx(sr_state);
            hist[i] = dout;
            tick();
            chk(idx >= 0 && sr_state == win(idx + 1), "R8 step after convergence",
                sr_state, (idx >= 0) ? win(idx + 1) : 0);
            if (i >= 6)
               chk(hist[i] == hist[i-6], "R9 period 6 after convergence", hist[i], hist[i-6]);
         end
         en = 1'b0;
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_pattern();
      t_hold();
      t_preset();
      t_feedback();
      t_converge();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule